// File: doc/BRIEF.md
# Reload Counter with Edge and Center-Aligned Modes

This block is the counting heart of a general timer. A tick input paced by the prescaler drives a counter whose period is held in an active register. The period and the prescale ratio are written into preload inputs. They only take effect when an update event occurs. Three counting shapes are offered: a rising sawtooth, a falling sawtooth, and a triangle. In the triangle shape the hardware owns the direction.

An update event comes either from the counter wrapping or from a software strobe. It copies both preloads into the active registers, pulses an event output and raises a sticky interrupt flag. An update-disable input suppresses updates caused by wrapping, so new preload values can be staged safely. A request-select input stops a software strobe from raising the flag. The active period and the active prescale ratio both reset to zero, so software normally issues one strobe before it starts counting.

Top module: `reload_counter`

## Requirements
- R1: Synchronous reset clears the counter, the direction, the event pulses, the flag, the internal enable, the prescaler counter, and the active period and ratio.
- R2: A change of `en_i` reaches the counting logic one clock later. While that delayed enable is low, the counter holds its value.
- R3: With `cmode_i`=00 and `dir_i`=0, each counting step adds one. When a step finds the counter at or above the active period, the counter goes to 0 instead, and `ovf_o` is high for one cycle.
- R4: With `cmode_i`=00 and `dir_i`=1, each step subtracts one. A step at 0 reloads the active period (or the preload, if this step is an update) and pulses `unf_o`. In this shape `dir_o` shows `dir_i` one cycle later.
- R5: With a nonzero `cmode_i`, the counter rises from 0. The step leaving period−1 lands on the period, pulses `ovf_o` and sets `dir_o`=1. The counter then falls, and the step leaving 1 lands on 0, pulses `unf_o` and clears `dir_o`. In this shape `dir_i` is ignored. An active period of 0 gives an overflow on every step, with the counter held at 0.
- R6: With a ratio S active, the counter takes one step for every S+1 cycles in which both the delayed enable and `tick_i` are high.
- R7: A wrap with `upd_dis_i`=0 is an update. `uev_o` pulses, and both preloads become active from the next step on. A falling reload on this wrap uses the new period.
- R8: A wrap with `upd_dis_i`=1 still wraps the counter, but there is no `uev_o`, no flag, and the active period and ratio stay as they were.
- R9: `swupd_i` takes priority over counting and is not blocked by `upd_dis_i`. It loads both preloads and pulses `uev_o`. It clears the prescaler counter and sets the counter to `period_pre_i` in the falling shape, and to 0 otherwise. In the triangle shape it also sets the direction to rising.
- R10: `uif_o` is set by every update except a strobe made while `urs_i`=1. It stays set until `flag_clr_i`, and a set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count tick into the prescaler |
| en_i | input | 1 | Counter enable |
| dir_i | input | 1 | Direction in edge shapes, 0 up, 1 down |
| cmode_i | input | 2 | 00 edge shape, nonzero triangle shape |
| upd_dis_i | input | 1 | Suppress updates caused by wrapping |
| urs_i | input | 1 | Software strobe does not set the flag |
| swupd_i | input | 1 | Software update strobe |
| period_pre_i | input | CNT_W | Period preload |
| psc_pre_i | input | PSC_W | Prescale ratio preload (divide by value+1) |
| flag_clr_i | input | 1 | Clear the update flag |
| cnt_o | output | CNT_W | Counter value |
| dir_o | output | 1 | Current direction, 1 = down |
| uev_o | output | 1 | Update event pulse |
| uif_o | output | 1 | Sticky update flag |
| ovf_o | output | 1 | Overflow pulse |
| unf_o | output | 1 | Underflow pulse |

## Verification
The bench targets the points where a counter that is nearly right would drift. The first is the falling reload on an updating wrap. A design that reloads the old period there produces one period of the wrong length after each period change. Another target is the blocked update. A design that still copies the preloads while updates are disabled would pick up the staged period too early. The bench also covers the triangle turnarounds, where an off-by-one at the top or the bottom stretches the triangle or produces a doubled value. Last, it covers the silent strobe and the tie between setting and clearing the flag. A design that gets these wrong either raises a flag nobody asked for or loses an event.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    SHAPE_EDGE   = 2'b00,
    SHAPE_TRI_DN = 2'b01,
    SHAPE_TRI_UP = 2'b10,
    SHAPE_TRI_BO = 2'b11
  } shape_e;

  function automatic logic is_tri(input logic [1:0] m);
    return m != SHAPE_EDGE;
  endfunction
endpackage

// File: rtl/rc_prescaler.sv
module rc_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             load_i,
  input  logic [PSC_W-1:0] psc_pre_i,
  output logic             step_o
);
  logic [PSC_W-1:0] pc_q;
  logic [PSC_W-1:0] ratio_q;
  logic             at_end;

  assign at_end = pc_q >= ratio_q;
  assign step_o = run_i & at_end & ~restart_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      ratio_q <= '0;
    end else begin
      if (restart_i)   pc_q <= '0;
      else if (run_i)  pc_q <= at_end ? '0 : pc_q + 1'b1;
      if (load_i) ratio_q <= psc_pre_i;
    end
  end
endmodule

// File: rtl/rc_core.sv
module rc_core
  import rc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             restart_i,
  input  logic             dir_i,
  input  logic [1:0]       cmode_i,
  input  logic             upd_dis_i,
  input  logic [CNT_W-1:0] period_pre_i,
  output logic             upd_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n, arr_q;
  logic             hd_q, hd_n, ovf_c, unf_c, tri_m;

  assign tri_m = is_tri(cmode_i);

  always_comb begin
    cnt_n = cnt_q;
    hd_n  = tri_m ? hd_q : dir_i;
    ovf_c = 1'b0;
    unf_c = 1'b0;
    if (restart_i) begin
      cnt_n = (!tri_m && dir_i) ? period_pre_i : '0;
      hd_n  = tri_m ? 1'b0 : dir_i;
    end else if (step_i) begin
      if (!tri_m) begin
        if (!dir_i) begin
          if (cnt_q >= arr_q) begin
            cnt_n = '0;
            ovf_c = 1'b1;
          end else cnt_n = cnt_q + 1'b1;
        end else begin
          if (cnt_q == '0) begin
            cnt_n = upd_dis_i ? arr_q : period_pre_i;
            unf_c = 1'b1;
          end else cnt_n = cnt_q - 1'b1;
        end
      end else if (!hd_q) begin
        if (arr_q == '0) begin
          cnt_n = '0;
          ovf_c = 1'b1;
        end else if (cnt_q >= arr_q - 1'b1) begin
          cnt_n = arr_q;
          ovf_c = 1'b1;
          hd_n  = 1'b1;
        end else cnt_n = cnt_q + 1'b1;
      end else begin
        if (cnt_q <= CNT_W'(1)) begin
          cnt_n = '0;
          unf_c = 1'b1;
          hd_n  = 1'b0;
        end else cnt_n = cnt_q - 1'b1;
      end
    end
  end

  assign upd_o = restart_i | ((ovf_c | unf_c) & ~upd_dis_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      arr_q <= '0;
      hd_q  <= 1'b0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      hd_q  <= hd_n;
      ovf_o <= ovf_c;
      unf_o <= unf_c;
      if (upd_o) arr_q <= period_pre_i;
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = hd_q;
endmodule

// File: rtl/rc_flag.sv
module rc_flag (
  input  logic clk,
  input  logic rst,
  input  logic upd_i,
  input  logic quiet_i,
  input  logic clr_i,
  output logic uev_o,
  output logic uif_o
);
  logic set_c;
  assign set_c = upd_i & ~quiet_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      uev_o <= 1'b0;
      uif_o <= 1'b0;
    end else begin
      uev_o <= upd_i;
      uif_o <= set_c | (uif_o & ~clr_i);
    end
  end
endmodule

// File: rtl/reload_counter.sv
module reload_counter #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             dir_i,
  input  logic [1:0]       cmode_i,
  input  logic             upd_dis_i,
  input  logic             urs_i,
  input  logic             swupd_i,
  input  logic [CNT_W-1:0] period_pre_i,
  input  logic [PSC_W-1:0] psc_pre_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             uev_o,
  output logic             uif_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic en_q, step, upd;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en_i;
  end

  rc_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .run_i(en_q & tick_i), .restart_i(swupd_i),
    .load_i(upd), .psc_pre_i(psc_pre_i), .step_o(step)
  );

  rc_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .step_i(step), .restart_i(swupd_i), .dir_i(dir_i),
    .cmode_i(cmode_i), .upd_dis_i(upd_dis_i), .period_pre_i(period_pre_i),
    .upd_o(upd), .cnt_o(cnt_o), .dir_o(dir_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  rc_flag u_flag (
    .clk(clk), .rst(rst), .upd_i(upd), .quiet_i(swupd_i & urs_i),
    .clr_i(flag_clr_i), .uev_o(uev_o), .uif_o(uif_o)
  );
endmodule

// File: rtl/rc_chk.sv
module rc_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic [1:0]       cmode_i,
  input logic             dir_i,
  input logic             upd_dis_i,
  input logic             swupd_i,
  input logic             flag_clr_i,
  input logic [CNT_W-1:0] period_pre_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             uev_o,
  input logic             uif_o,
  input logic             ovf_o,
  input logic             unf_o
);
  assert_en_delay_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(swupd_i) && !$past(en_i, 2)) |-> $stable(cnt_o));

  assert_up_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !$past(rst) && $past(cmode_i) == 2'b00) |-> cnt_o == '0);

  assert_one_edge_R5: assert property (@(posedge clk) disable iff (rst)
    !(ovf_o && unf_o));

  assert_no_uev_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    ((ovf_o || unf_o) && !$past(rst) && $past(upd_dis_i) && !$past(swupd_i)) |-> !uev_o);

  assert_sw_restart_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(swupd_i) && !$past(rst)) |->
      (uev_o && cnt_o == (($past(cmode_i) == 2'b00 && $past(dir_i)) ? $past(period_pre_i) : '0)));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(uif_o) && !$past(flag_clr_i) && !$past(rst)) |-> uif_o);
endmodule

bind reload_counter rc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .cmode_i(cmode_i), .dir_i(dir_i),
  .upd_dis_i(upd_dis_i), .swupd_i(swupd_i), .flag_clr_i(flag_clr_i),
  .period_pre_i(period_pre_i), .cnt_o(cnt_o), .uev_o(uev_o), .uif_o(uif_o),
  .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/sim_reload_counter.sv
module sim_reload_counter;
  localparam int CW = 8;
  localparam int PW = 4;

  typedef struct packed {
    logic [CW-1:0] cnt;
    logic dir, uev, uif, ovf, unf;
    logic [15:0] tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic tick = 1'b0, en = 1'b0, dir = 1'b0, dis = 1'b0, urs = 1'b0, sw = 1'b0, clr = 1'b0;
  logic [1:0] cm = 2'b00;
  logic [CW-1:0] per = '0;
  logic [PW-1:0] psc = '0;
  logic [CW-1:0] cnt;
  logic d_o, uev, uif, ovf, unf;

  int total = 0, bad = 0;
  bit mon_on = 0;
  exp_t q[$];

  logic [CW-1:0] m_cnt = '0, m_arr = '0;
  logic [PW-1:0] m_psc = '0, m_pc = '0;
  logic m_en = 0, m_hd = 0, m_uif = 0;

  always #5 clk = ~clk;

  reload_counter #(.CNT_W(CW), .PSC_W(PW)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .en_i(en), .dir_i(dir), .cmode_i(cm),
    .upd_dis_i(dis), .urs_i(urs), .swupd_i(sw), .period_pre_i(per), .psc_pre_i(psc),
    .flag_clr_i(clr), .cnt_o(cnt), .dir_o(d_o), .uev_o(uev), .uif_o(uif),
    .ovf_o(ovf), .unf_o(unf)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] ex, input string req, input string what);
    total++;
    if (act !== ex) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, ex);
    end
  endtask

  // One cycle of stimulus; the expected outputs after the next edge are pushed.
  task automatic cyc(input logic e, input logic t, input logic d, input logic [1:0] m,
                     input logic ds, input logic u, input logic s, input logic [CW-1:0] p,
                     input logic [PW-1:0] ps, input logic c, input logic [15:0] tag);
    exp_t x;
    logic step, o, n, up, tri_m;
    @(negedge clk);
    en = e; tick = t; dir = d; cm = m; dis = ds; urs = u; sw = s; per = p; psc = ps; clr = c;
    tri_m = (m != 2'b00);
    step = 0; o = 0; n = 0;
    if (s) begin
      m_pc = '0;
      m_cnt = (!tri_m && d) ? p : '0;
      m_hd = tri_m ? 1'b0 : d;
    end else begin
      if (!tri_m) m_hd = d;
      if (m_en && t) begin
        if (m_pc >= m_psc) begin m_pc = '0; step = 1; end
        else m_pc = m_pc + 1'b1;
      end
      if (step) begin
        if (!tri_m && !d) begin
          if (m_cnt >= m_arr) begin m_cnt = '0; o = 1; end else m_cnt++;
        end else if (!tri_m) begin
          if (m_cnt == 0) begin m_cnt = ds ? m_arr : p; n = 1; end else m_cnt--;
        end else if (!m_hd) begin
          if (m_arr == 0) begin o = 1; end
          else if (m_cnt + 1 == m_arr) begin m_cnt = m_arr; o = 1; m_hd = 1; end
          else m_cnt++;
        end else begin
          if (m_cnt == 1) begin m_cnt = '0; n = 1; m_hd = 0; end else m_cnt--;
        end
      end
    end
    up = s || ((o || n) && !ds);
    if (up) begin m_arr = p; m_psc = ps; end
    m_uif = (up && !(s && u)) || (m_uif && !c);
    m_en = e;
    x.cnt = m_cnt; x.dir = m_hd; x.uev = up; x.uif = m_uif; x.ovf = o; x.unf = n; x.tag = tag;
    q.push_back(x);
  endtask

  // Monitor: compares after every rising edge.
  always @(posedge clk) begin
    if (mon_on) begin
      #1;
      if (q.size() > 0) begin
        exp_t x;
        string r;
        x = q.pop_front();
        r = string'(x.tag);
        chk(cnt, x.cnt, r, "cnt");
        chk(d_o, x.dir, r, "dir");
        chk(uev, x.uev, r, "uev");
        chk(uif, x.uif, r, "uif");
        chk(ovf, x.ovf, r, "ovf");
        chk(unf, x.unf, r, "unf");
      end
    end
  end

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(cnt, 0, "R1", "cnt"); chk(d_o, 0, "R1", "dir"); chk(uif, 0, "R1", "uif");
    chk(uev, 0, "R1", "uev"); chk(ovf | unf, 0, "R1", "pulses");
    mon_on = 1;
    // R9 strobe loads period 4, ratio 0
    cyc(0,1,0,2'b00,0,0,1,8'd4,4'd0,0,"R9");
    // R2 enable delay, then R3 rising count
    cyc(1,1,0,2'b00,0,0,0,8'd4,4'd0,0,"R2");
    cyc(1,1,0,2'b00,0,0,0,8'd4,4'd0,0,"R2");
    for (int i = 0; i < 12; i++) cyc(1,1,0,2'b00,0,0,0,8'd4,4'd0,0,"R3");
    // R2 hold while disabled
    for (int i = 0; i < 4; i++) cyc(0,1,0,2'b00,0,0,0,8'd4,4'd0,0,"R2");
    // R10 clear flag
    cyc(0,1,0,2'b00,0,0,0,8'd4,4'd0,1,"R10");
    // R4 falling count, restart then run; R7 period change mid-run
    cyc(1,1,1,2'b00,0,0,1,8'd3,4'd0,0,"R9");
    for (int i = 0; i < 6; i++) cyc(1,1,1,2'b00,0,0,0,8'd3,4'd0,0,"R4");
    for (int i = 0; i < 8; i++) cyc(1,1,1,2'b00,0,0,0,8'd5,4'd0,0,"R7");
    // R6 prescaler ratio 2 with gaps in the tick
    cyc(1,1,0,2'b00,0,0,1,8'd3,4'd2,0,"R9");
    for (int i = 0; i < 20; i++) cyc(1,(i % 3 != 1),0,2'b00,0,0,0,8'd3,4'd2,0,"R6");
    // R8 updates blocked, staged period ignored in both shapes
    cyc(1,1,0,2'b00,0,0,1,8'd2,4'd0,1,"R9");
    for (int i = 0; i < 8; i++) cyc(1,1,0,2'b00,1,0,0,8'd6,4'd3,1,"R8");
    for (int i = 0; i < 8; i++) cyc(1,1,1,2'b00,1,0,0,8'd6,4'd3,0,"R8");
    // R7 unblocked: new period takes over at next wrap
    for (int i = 0; i < 10; i++) cyc(1,1,0,2'b00,0,0,0,8'd6,4'd0,0,"R7");
    // R5 triangle, dir_i toggled and ignored, several mode codes
    cyc(1,1,0,2'b01,0,0,1,8'd3,4'd0,0,"R9");
    for (int i = 0; i < 14; i++) cyc(1,1,i[0],2'b01,0,0,0,8'd3,4'd0,0,"R5");
    for (int i = 0; i < 8; i++) cyc(1,1,1,2'b11,0,0,0,8'd3,4'd0,0,"R5");
    cyc(1,1,0,2'b10,0,0,1,8'd0,4'd0,0,"R9");
    for (int i = 0; i < 4; i++) cyc(1,1,0,2'b10,0,0,0,8'd0,4'd0,0,"R5");
    // R10 quiet strobe, set versus clear tie
    cyc(0,0,0,2'b00,0,0,0,8'd4,4'd0,1,"R10");
    cyc(0,0,0,2'b00,0,1,1,8'd4,4'd0,0,"R10");
    cyc(0,0,0,2'b00,0,1,0,8'd4,4'd0,0,"R10");
    cyc(0,0,0,2'b00,0,0,1,8'd4,4'd0,1,"R10");
    cyc(0,0,0,2'b00,0,0,0,8'd4,4'd0,0,"R10");
    cyc(0,0,0,2'b00,0,1,1,8'd4,4'd0,1,"R10");
    cyc(0,0,0,2'b00,0,0,0,8'd4,4'd0,0,"R10");
    repeat (3) @(posedge clk);
    #2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule